// File: doc/BRIEF.md
# Program Counter Wait-Loop Monitor

This debug block sits next to a CPU core and watches the stream of retired instructions. Each time the core signals that an instruction has retired, the monitor compares that instruction's program counter with the one before it. It keeps a count of how many retirements in a row have used the same address. When the count reaches a configurable threshold, the monitor decides that the program is spinning in a wait loop.

On that same clock edge the monitor freezes a snapshot for a debug reader. The snapshot holds the looping address, the interrupt master enable bit, the interrupt enable and request registers, and the display control, status and line registers. The monitor also decodes the snapshot into a few simple answers:

- which enabled interrupts are actually pending,
- whether any interrupt is pending at all,
- whether the display was on,
- which display mode was active.

These answers tell the reader what the spinning code is most likely waiting for. The flag and the snapshot stay in place until the debug side pulses a clear, so a long-running loop cannot overwrite the first capture.

Top module: `pc_spin_monitor`

## Requirements
- R1: After reset, `loop_found_o` and every snapshot and decoded output read zero.
- R2: `loop_found_o` rises on the clock edge at which the THRESHOLD-th consecutive retirement at the same PC is sampled (default THRESHOLD 5000). A run of THRESHOLD-1 retirements does not raise it.
- R3: A retirement whose PC differs from the previous retired PC restarts the run count at 1. The run then needs THRESHOLD retirements of the new PC.
- R4: Cycles with `retire_i` low neither extend nor break a run.
- R5: On detection, the snapshot outputs hold the PC and the IME, IE, IF, LCDC, STAT and LY values that were present with the detecting retirement.
- R6: While `loop_found_o` is high and `clear_i` is low, the flag and all snapshot and decoded outputs stay constant, even if the loop continues or another loop reaches the threshold.
- R7: A `clear_i` pulse zeroes the flag and all snapshot outputs on the next edge and restarts the run count. A retirement sampled together with `clear_i` is not counted.
- R8: `pend_o[i]` = IME AND IE[i] AND IF[i] for i = 0..4, taken from the captured values. Bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is joypad. `pend_any_o` is the OR of `pend_o`. IE and IF bits 7:5 never affect either output.
- R9: `disp_on_o` is captured LCDC bit 7, and `disp_mode_o` is captured STAT bits 1:0.
- R10: The internal run counter saturates at THRESHOLD and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| pc_i | input | 16 | Address of the retiring instruction |
| ime_i | input | 1 | Interrupt master enable |
| ie_i | input | 8 | Interrupt enable register |
| if_i | input | 8 | Interrupt request register |
| lcdc_i | input | 8 | Display control register |
| stat_i | input | 8 | Display status register |
| ly_i | input | 8 | Current display line |
| clear_i | input | 1 | Releases the held snapshot and restarts counting |
| loop_found_o | output | 1 | Wait loop detected and held |
| loop_pc_o | output | 16 | Captured looping PC |
| snap_ime_o | output | 1 | Captured IME |
| snap_ie_o | output | 8 | Captured IE |
| snap_if_o | output | 8 | Captured IF |
| snap_lcdc_o | output | 8 | Captured LCDC |
| snap_stat_o | output | 8 | Captured STAT |
| snap_ly_o | output | 8 | Captured LY |
| pend_o | output | 5 | Captured pending-interrupt vector |
| pend_any_o | output | 1 | Any captured interrupt pending |
| disp_on_o | output | 1 | Captured display-on bit |
| disp_mode_o | output | 2 | Captured display mode |

## Verification
The flag and the full snapshot change on the same rising edge that samples the THRESHOLD-th matching retirement. The bench therefore expects them at the falling edge that follows that retirement, and it fails any rise that comes one retirement early or late. The driver places each expected snapshot in the scoreboard before it sends the final retirement. The monitor pops that entry only when it sees the flag rise at a falling edge, and an empty queue afterwards confirms that the rise came on time.

The effect of a clear is checked at the falling edge after the edge that sampled it. The checks that a run did not trigger are made at the falling edge after the last retirement of that run.

// File: rtl/spin_pkg.sv
package spin_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned IRQ_N       = 5;
  localparam int unsigned IRQ_VBLANK  = 0;
  localparam int unsigned IRQ_DSTAT   = 1;
  localparam int unsigned IRQ_TIMER   = 2;
  localparam int unsigned IRQ_SERIAL  = 3;
  localparam int unsigned IRQ_JOYPAD  = 4;
  localparam int unsigned DISP_ON_BIT = 7;
  localparam int unsigned MODE_W      = 2;

  typedef struct packed {
    logic             ime;
    logic [REG_W-1:0] ie;
    logic [REG_W-1:0] iflag;
    logic [REG_W-1:0] lcdc;
    logic [REG_W-1:0] stat;
    logic [REG_W-1:0] ly;
  } ctx_t;

  typedef struct packed {
    logic [IRQ_N-1:0]  pend;
    logic              any;
    logic              disp_on;
    logic [MODE_W-1:0] mode;
  } decode_t;
endpackage

// File: rtl/pc_run_counter.sv
module pc_run_counter #(
  parameter int unsigned THRESHOLD = 5000,
  parameter int unsigned PC_W      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            retire,
  input  logic [PC_W-1:0] pc,
  output logic            hit
);
  localparam int unsigned CNT_W = $clog2(THRESHOLD + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [PC_W-1:0]  last_pc;
  logic             seen;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             same;

  assign same = seen && (pc == last_pc);

  always_comb begin
    cnt_nx = cnt;
    if (retire) begin
      if (!same)             cnt_nx = ONE;
      else if (cnt != LIMIT) cnt_nx = cnt + ONE;
    end
  end

  // Fires once per run: the retirement that first brings the count to LIMIT.
  assign hit = retire && !restart && (cnt_nx == LIMIT) && !(same && cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt     <= '0;
      seen    <= 1'b0;
      last_pc <= '0;
    end else if (retire) begin
      cnt     <= cnt_nx;
      last_pc <= pc;
      seen    <= 1'b1;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst) cnt <= LIMIT); // R10
  AST_NEW_PC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (retire && !restart && seen && pc != last_pc) |=> cnt == ONE); // R3
  AST_IDLE_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (!retire && !restart) |=> $stable(cnt)); // R4
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !seen)); // R7
endmodule

// File: rtl/status_decode.sv
module status_decode
  import spin_pkg::*;
(
  input  ctx_t    ctx,
  output decode_t dec
);
  logic [IRQ_N-1:0] pend;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_pend
    assign pend[g] = ctx.ime & ctx.ie[g] & ctx.iflag[g];
  end

  always_comb begin
    dec.pend    = pend;
    dec.any     = |pend;
    dec.disp_on = ctx.lcdc[DISP_ON_BIT];
    dec.mode    = ctx.stat[MODE_W-1:0];
  end
endmodule

// File: rtl/snapshot_hold.sv
module snapshot_hold
  import spin_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            capture,
  input  logic [PC_W-1:0] pc,
  input  ctx_t            ctx,
  input  decode_t         dec,
  output logic            found,
  output logic [PC_W-1:0] snap_pc,
  output ctx_t            snap_ctx,
  output decode_t         snap_dec
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found    <= 1'b0;
      snap_pc  <= '0;
      snap_ctx <= '0;
      snap_dec <= '0;
    end else if (capture && !found) begin
      found    <= 1'b1;
      snap_pc  <= pc;
      snap_ctx <= ctx;
      snap_dec <= dec;
    end
  end

  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (found && !clear) |=> (found && $stable(snap_pc) && $stable(snap_ctx) && $stable(snap_dec))); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!found && snap_pc == '0 && snap_ctx == '0 && snap_dec == '0)); // R7
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(capture)); // R2
endmodule

// File: rtl/pc_spin_monitor.sv
module pc_spin_monitor
  import spin_pkg::*;
#(
  parameter int unsigned THRESHOLD = 5000,
  parameter int unsigned PC_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              ime_i,
  input  logic [REG_W-1:0]  ie_i,
  input  logic [REG_W-1:0]  if_i,
  input  logic [REG_W-1:0]  lcdc_i,
  input  logic [REG_W-1:0]  stat_i,
  input  logic [REG_W-1:0]  ly_i,
  input  logic              clear_i,
  output logic              loop_found_o,
  output logic [PC_W-1:0]   loop_pc_o,
  output logic              snap_ime_o,
  output logic [REG_W-1:0]  snap_ie_o,
  output logic [REG_W-1:0]  snap_if_o,
  output logic [REG_W-1:0]  snap_lcdc_o,
  output logic [REG_W-1:0]  snap_stat_o,
  output logic [REG_W-1:0]  snap_ly_o,
  output logic [IRQ_N-1:0]  pend_o,
  output logic              pend_any_o,
  output logic              disp_on_o,
  output logic [MODE_W-1:0] disp_mode_o
);
  ctx_t    live_ctx, held_ctx;
  decode_t live_dec, held_dec;
  logic    hit;

  assign live_ctx = '{ime: ime_i, ie: ie_i, iflag: if_i, lcdc: lcdc_i, stat: stat_i, ly: ly_i};

  pc_run_counter #(.THRESHOLD(THRESHOLD), .PC_W(PC_W)) u_run (
    .clk(clk), .rst(rst), .restart(clear_i), .retire(retire_i), .pc(pc_i), .hit(hit)
  );

  status_decode u_dec (.ctx(live_ctx), .dec(live_dec));

  snapshot_hold #(.PC_W(PC_W)) u_hold (
    .clk(clk), .rst(rst), .clear(clear_i), .capture(hit), .pc(pc_i),
    .ctx(live_ctx), .dec(live_dec),
    .found(loop_found_o), .snap_pc(loop_pc_o), .snap_ctx(held_ctx), .snap_dec(held_dec)
  );

  assign snap_ime_o  = held_ctx.ime;
  assign snap_ie_o   = held_ctx.ie;
  assign snap_if_o   = held_ctx.iflag;
  assign snap_lcdc_o = held_ctx.lcdc;
  assign snap_stat_o = held_ctx.stat;
  assign snap_ly_o   = held_ctx.ly;
  assign pend_o      = held_dec.pend;
  assign pend_any_o  = held_dec.any;
  assign disp_on_o   = held_dec.disp_on;
  assign disp_mode_o = held_dec.mode;

  AST_PEND_NEEDS_IME: assert property (@(posedge clk) disable iff (rst)
    !snap_ime_o |-> (pend_o == '0 && !pend_any_o)); // R8
  AST_CAPTURE_PC: assert property (@(posedge clk) disable iff (rst)
    (hit && !loop_found_o && !clear_i) |=> (loop_found_o && loop_pc_o == $past(pc_i))); // R5
endmodule

// File: tb/pc_spin_monitor_test.sv
module pc_spin_monitor_test;
  localparam int T = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic ime_i = 1'b0;
  logic [7:0] ie_i = '0, if_i = '0, lcdc_i = '0, stat_i = '0, ly_i = '0;
  logic clear_i = 1'b0;
  logic loop_found_o, snap_ime_o, pend_any_o, disp_on_o;
  logic [15:0] loop_pc_o;
  logic [7:0] snap_ie_o, snap_if_o, snap_lcdc_o, snap_stat_o, snap_ly_o;
  logic [4:0] pend_o;
  logic [1:0] disp_mode_o;

  always #5 clk = ~clk;

  pc_spin_monitor uut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .pc_i(pc_i), .ime_i(ime_i),
    .ie_i(ie_i), .if_i(if_i), .lcdc_i(lcdc_i), .stat_i(stat_i), .ly_i(ly_i),
    .clear_i(clear_i), .loop_found_o(loop_found_o), .loop_pc_o(loop_pc_o),
    .snap_ime_o(snap_ime_o), .snap_ie_o(snap_ie_o), .snap_if_o(snap_if_o),
    .snap_lcdc_o(snap_lcdc_o), .snap_stat_o(snap_stat_o), .snap_ly_o(snap_ly_o),
    .pend_o(pend_o), .pend_any_o(pend_any_o), .disp_on_o(disp_on_o),
    .disp_mode_o(disp_mode_o)
  );

  typedef struct {
    logic [15:0] pc; logic ime; logic [7:0] ie, ifl, lcdc, stat, ly;
    logic [4:0] pend; logic any, on; logic [1:0] mode;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic prev_found = 1'b0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic set_ctx(logic ime, logic [7:0] ie, logic [7:0] ifl,
                         logic [7:0] lcdc, logic [7:0] stat, logic [7:0] ly);
    ime_i = ime; ie_i = ie; if_i = ifl; lcdc_i = lcdc; stat_i = stat; ly_i = ly;
  endtask

  // Expected snapshot built from the requirements (R5, R8, R9).
  task automatic push_exp(logic [15:0] pc);
    exp_t e;
    e.pc = pc; e.ime = ime_i; e.ie = ie_i; e.ifl = if_i;
    e.lcdc = lcdc_i; e.stat = stat_i; e.ly = ly_i;
    e.pend = ime_i ? (ie_i[4:0] & if_i[4:0]) : 5'd0;
    e.any  = (e.pend != 5'd0);
    e.on   = lcdc_i[7];
    e.mode = stat_i[1:0];
    q.push_back(e);
  endtask

  task automatic run_pc(logic [15:0] pc, int n, int gap_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire_i = 1'b1; pc_i = pc;
      if (gap_every != 0 && (i % gap_every) == gap_every - 1) begin
        @(negedge clk); retire_i = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk); retire_i = 1'b0;
  endtask

  task automatic check_all_zero(string req);
    chk(req, {31'd0, loop_found_o}, 0);
    chk(req, {loop_pc_o, snap_ie_o, snap_if_o}, 0);
    chk(req, {snap_lcdc_o, snap_stat_o, snap_ly_o, snap_ime_o}, 0);
    chk(req, {pend_o, pend_any_o, disp_on_o, disp_mode_o}, 0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor: pops an expected item on each rising detection.
  always @(negedge clk) begin
    if (rst) prev_found = 1'b0;
    else begin
      if (loop_found_o && !prev_found) begin
        if (q.size() == 0) chk("R2 unexpected detection", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R5 pc", loop_pc_o, e.pc);
          chk("R5 ime", snap_ime_o, e.ime);
          chk("R5 ie/if", {snap_ie_o, snap_if_o}, {e.ie, e.ifl});
          chk("R5 lcdc/stat/ly", {snap_lcdc_o, snap_stat_o, snap_ly_o}, {e.lcdc, e.stat, e.ly});
          chk("R8 pending", {pend_o, pend_any_o}, {e.pend, e.any});
          chk("R9 display", {disp_on_o, disp_mode_o}, {e.on, e.mode});
        end
      end
      prev_found = loop_found_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all_zero("R1 reset");

    // R2 boundary: one short of the threshold
    run_pc(16'h1000, T - 1, 0);
    chk("R2 below threshold", loop_found_o, 0);
    // R3: a different PC breaks the run; the old PC must start over
    run_pc(16'h2000, 1, 0);
    run_pc(16'h1000, T - 1, 0);
    chk("R3 interrupted run", loop_found_o, 0);

    // R2/R4/R5/R8/R9: detection with idle gaps inside the run
    set_ctx(1'b1, 8'h1F, 8'h05, 8'h91, 8'h03, 8'h42);
    push_exp(16'h0150);
    run_pc(16'h0150, T, 7);
    @(negedge clk);
    chk("R2 detection on time", q.size(), 0);
    chk("R2 flag high", loop_found_o, 1);

    // R6: later inputs and a second full loop leave the snapshot alone
    set_ctx(1'b0, 8'h00, 8'hFF, 8'h00, 8'h01, 8'h99);
    run_pc(16'h0150, 50, 0);
    run_pc(16'h0200, T, 0);
    chk("R6 held pc", loop_pc_o, 16'h0150);
    chk("R6 held ly/ie", {snap_ly_o, snap_ie_o}, {8'h42, 8'h1F});
    chk("R6 held decode", {pend_o, disp_mode_o}, {5'h05, 2'd3});

    // R7: clear together with a retirement; that retirement is not counted
    @(negedge clk); clear_i = 1'b1; retire_i = 1'b1; pc_i = 16'h0300;
    @(negedge clk); clear_i = 1'b0; retire_i = 1'b0;
    check_all_zero("R7 cleared");
    set_ctx(1'b0, 8'hFF, 8'hFF, 8'h11, 8'h02, 8'h07);
    run_pc(16'h0300, T - 1, 0);
    chk("R7 clear-cycle retire not counted", loop_found_o, 0);
    push_exp(16'h0300);        // R8: IME low gives no pending bits
    run_pc(16'h0300, 1, 0);
    @(negedge clk);
    chk("R7 redetect after clear", q.size(), 0);

    // R8: upper IE/IF bits masked, serial and joypad decoded
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    chk("R7 flag cleared", loop_found_o, 0);
    set_ctx(1'b1, 8'hF8, 8'hFC, 8'h80, 8'h85, 8'h90);
    push_exp(16'hFFFF);
    run_pc(16'hFFFF, T, 0);
    @(negedge clk);
    chk("R8 detection on time", q.size(), 0);

    while (q.size() != 0) begin
      void'(q.pop_front());
      chk("R2 missing detection", 0, 1);
    end
    finish_up();
  end
endmodule